// File: doc/BRIEF.md
# Dual Signal Quality Integrator

This block sums two per-symbol receiver quality metrics over a fixed window of accepted symbols and judges each total against its own programmable limit. The first metric is the correlator peak magnitude, where a larger total means a stronger signal. The second is the absolute phase error, where a smaller total means a cleaner signal. A symbol counts only when its valid strobe is high.

The window is short (16 symbols) while the receiver is acquiring a signal and long (128 symbols) once it is demodulating data. When a window completes, the block registers both totals and a pass flag for each. It also raises a one-cycle done pulse and then starts a fresh window. A combined quality flag is high only when both metrics pass. The mode input sets the length of each window on that window's first symbol, so a window is never cut short or stretched.

Top module: `sigQualIntegrator`

## Requirements
- R1: While reset (active-low `rstN`) is asserted, `blockDone`, `magSum`, `phsSum`, `magPass`, `phsPass` and `qualOk` are all zero.
- R2: With `trackMode` = 0 at the first symbol of a window, the window closes on its 16th accepted symbol.
- R3: With `trackMode` = 1 at the first symbol of a window, the window closes on its 128th accepted symbol.
- R4: At window close, `magSum` equals the exact sum of the window's `magIn` samples. 128 full-scale samples (32640) do not overflow.
- R5: At window close, `phsSum` equals the exact sum of the window's `phsErrIn` samples, with the same full-scale range as R4.
- R6: `magPass` is 1 when the window's magnitude total is greater than or equal to `magThresh`, sampled on the closing symbol's cycle.
- R7: `phsPass` is 1 when the window's phase error total is strictly less than `phsThresh`, sampled on the closing symbol's cycle.
- R8: `qualOk` is 1 exactly when both `magPass` and `phsPass` are 1.
- R9: `blockDone` is high for exactly one cycle, in the cycle after the closing symbol's clock edge. The totals and flags then hold until the next window closes.
- R10: Samples presented while `symValid` is 0 are neither counted nor added.
- R11: Changing `trackMode` after a window's first symbol does not change that window's length. The new value applies from the next window's first symbol.
- R12: Each window's totals contain only that window's samples; the sums restart after every close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| symValid | input | 1 | One accepted symbol per cycle when high |
| magIn | input | MAG_W | Correlator peak magnitude of the symbol |
| phsErrIn | input | PHS_W | Absolute phase error of the symbol |
| trackMode | input | 1 | 0 = acquisition (short window), 1 = data demodulation (long window) |
| magThresh | input | MACC_W | Minimum passing magnitude total |
| phsThresh | input | PACC_W | Phase error total must be below this to pass |
| blockDone | output | 1 | One-cycle pulse after a window closes |
| magSum | output | MACC_W | Magnitude total of the last closed window |
| phsSum | output | PACC_W | Phase error total of the last closed window |
| magPass | output | 1 | Magnitude verdict of the last closed window |
| phsPass | output | 1 | Phase error verdict of the last closed window |
| qualOk | output | 1 | Both verdicts pass |

## Verification
The embedded assertions check on every cycle that the done pulse lasts a single cycle and follows an accepted symbol. They also check that the running sums never wrap inside a window, that the reported results stay still between closes, that the symbol count stays inside the current window, and that the latched window length does not move mid-window. Only the bench's scenarios can show the values themselves: exact totals, the equal-to-limit outcomes of the two compares with their opposite senses, the window lengths for each mode, and mode changes made mid-window. The bench shows these through a behavioural model compared on every clock, while inputs wiggle during idle cycles.

// File: rtl/sqiPkg.sv
package sqiPkg;
  typedef struct packed {
    logic accEn;
    logic winEnd;
  } sqiStrb_t;
endpackage

// File: rtl/sqiCtl.sv
module sqiCtl
  import sqiPkg::*;
#(
  parameter int SHORT_LEN = 16,
  parameter int LONG_LEN  = 128,
  parameter int CNT_W     = $clog2(LONG_LEN)
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     symValid,
  input  logic     trackMode,
  output sqiStrb_t strb
);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_LEN - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LEN - 1);

  logic [CNT_W-1:0] symCnt;
  logic             winLong;
  logic             lenLong;
  logic [CNT_W-1:0] lastIdx;

  // first symbol of a window takes the live mode, later ones the latched mode
  assign lenLong     = (symCnt == '0) ? trackMode : winLong;
  assign lastIdx     = lenLong ? LONG_LAST : SHORT_LAST;
  assign strb.accEn  = symValid;
  assign strb.winEnd = symValid && (symCnt == lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      symCnt  <= '0;
      winLong <= 1'b0;
    end else if (symValid) begin
      if (symCnt == '0) winLong <= trackMode;
      symCnt <= strb.winEnd ? '0 : symCnt + 1'b1;
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (symCnt != '0) |=> (winLong == $past(winLong))); // R11

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (symCnt != '0 && !winLong) |-> (symCnt <= SHORT_LAST)); // R2
endmodule

// File: rtl/sqiLane.sv
module sqiLane
  import sqiPkg::*;
#(
  parameter int IN_W        = 8,
  parameter int ACC_W       = 16,
  parameter bit LOW_IS_GOOD = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  sqiStrb_t         strb,
  input  logic [IN_W-1:0]  sample,
  input  logic [ACC_W-1:0] thresh,
  output logic [ACC_W-1:0] sum,
  output logic             pass
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] nextAcc;
  logic             verdict;

  assign nextAcc = acc + ACC_W'(sample);

  generate
    if (LOW_IS_GOOD) begin : g_lowGood
      assign verdict = nextAcc < thresh;
    end else begin : g_highGood
      assign verdict = nextAcc >= thresh;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc  <= '0;
      sum  <= '0;
      pass <= 1'b0;
    end else if (strb.accEn) begin
      if (strb.winEnd) begin
        acc  <= '0;
        sum  <= nextAcc;
        pass <= verdict;
      end else begin
        acc <= nextAcc;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accEn && !strb.winEnd) |=> (acc >= $past(acc))); // R4

  AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.accEn && strb.winEnd) |=> $stable(sum)); // R9
endmodule

// File: rtl/sqiDatapath.sv
module sqiDatapath
  import sqiPkg::*;
#(
  parameter int MAG_W  = 8,
  parameter int PHS_W  = 8,
  parameter int MACC_W = 16,
  parameter int PACC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  sqiStrb_t          strb,
  input  logic              symValid,
  input  logic [MAG_W-1:0]  magIn,
  input  logic [PHS_W-1:0]  phsErrIn,
  input  logic [MACC_W-1:0] magThresh,
  input  logic [PACC_W-1:0] phsThresh,
  output logic              blockDone,
  output logic [MACC_W-1:0] magSum,
  output logic [PACC_W-1:0] phsSum,
  output logic              magPass,
  output logic              phsPass,
  output logic              qualOk
);
  sqiLane #(.IN_W(MAG_W), .ACC_W(MACC_W), .LOW_IS_GOOD(1'b0)) i_magLane (
    .clk(clk), .rstN(rstN), .strb(strb), .sample(magIn),
    .thresh(magThresh), .sum(magSum), .pass(magPass)
  );

  sqiLane #(.IN_W(PHS_W), .ACC_W(PACC_W), .LOW_IS_GOOD(1'b1)) i_phsLane (
    .clk(clk), .rstN(rstN), .strb(strb), .sample(phsErrIn),
    .thresh(phsThresh), .sum(phsSum), .pass(phsPass)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) blockDone <= 1'b0;
    else       blockDone <= strb.accEn && strb.winEnd;
  end

  assign qualOk = magPass && phsPass;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |=> !blockDone); // R9

  AST_DONE_AFTER_SYM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blockDone) |-> $past(symValid)); // R10
endmodule

// File: rtl/sigQualIntegrator.sv
module sigQualIntegrator
  import sqiPkg::*;
#(
  parameter int MAG_W     = 8,
  parameter int PHS_W     = 8,
  parameter int SHORT_LEN = 16,
  parameter int LONG_LEN  = 128,
  localparam int SUM_GROW = $clog2(LONG_LEN + 1),
  localparam int MACC_W   = MAG_W + SUM_GROW,
  localparam int PACC_W   = PHS_W + SUM_GROW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              symValid,
  input  logic [MAG_W-1:0]  magIn,
  input  logic [PHS_W-1:0]  phsErrIn,
  input  logic              trackMode,
  input  logic [MACC_W-1:0] magThresh,
  input  logic [PACC_W-1:0] phsThresh,
  output logic              blockDone,
  output logic [MACC_W-1:0] magSum,
  output logic [PACC_W-1:0] phsSum,
  output logic              magPass,
  output logic              phsPass,
  output logic              qualOk
);
  localparam int CNT_W = $clog2(LONG_LEN);

  sqiStrb_t strb;

  sqiCtl #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .CNT_W(CNT_W)) i_ctl (
    .clk(clk), .rstN(rstN), .symValid(symValid), .trackMode(trackMode), .strb(strb)
  );

  sqiDatapath #(.MAG_W(MAG_W), .PHS_W(PHS_W), .MACC_W(MACC_W), .PACC_W(PACC_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .symValid(symValid),
    .magIn(magIn), .phsErrIn(phsErrIn),
    .magThresh(magThresh), .phsThresh(phsThresh),
    .blockDone(blockDone), .magSum(magSum), .phsSum(phsSum),
    .magPass(magPass), .phsPass(phsPass), .qualOk(qualOk)
  );
endmodule

// File: tb/test_sigQualIntegrator.sv
`timescale 1ns/1ps
module test_sigQualIntegrator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        symValid = 1'b0;
  logic [7:0]  magIn = '0;
  logic [7:0]  phsErrIn = '0;
  logic        trackMode = 1'b0;
  logic [15:0] magThresh = '0;
  logic [15:0] phsThresh = '0;
  logic        blockDone, magPass, phsPass, qualOk;
  logic [15:0] magSum, phsSum;

  int nChecks = 0, nFails = 0, doneCnt = 0;
  bit finished = 1'b0;

  // reference model state
  int  mCnt = 0, mAccM = 0, mAccP = 0;
  bit  mLong = 0;
  int  eMag = 0, ePhs = 0;
  bit  eDone = 0, eMagPass = 0, ePhsPass = 0;

  always #2.5 clk = ~clk;

  sigQualIntegrator i_sigQualIntegrator (
    .clk(clk), .rstN(rstN), .symValid(symValid), .magIn(magIn), .phsErrIn(phsErrIn),
    .trackMode(trackMode), .magThresh(magThresh), .phsThresh(phsThresh),
    .blockDone(blockDone), .magSum(magSum), .phsSum(phsSum),
    .magPass(magPass), .phsPass(phsPass), .qualOk(qualOk)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mAccM = 0; mAccP = 0; mLong = 0;
      eMag = 0; ePhs = 0; eDone = 0; eMagPass = 0; ePhsPass = 0;
    end else begin
      eDone = 0;
      if (symValid) begin
        if (mCnt == 0) mLong = trackMode;
        mAccM += int'(magIn);
        mAccP += int'(phsErrIn);
        mCnt++;
        if (mCnt == (mLong ? 128 : 16)) begin
          eMag = mAccM; ePhs = mAccP;
          eMagPass = (eMag >= int'(magThresh));
          ePhsPass = (ePhs < int'(phsThresh));
          eDone = 1;
          mCnt = 0; mAccM = 0; mAccP = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(blockDone === eDone, "R9 blockDone", int'(blockDone), int'(eDone));
      chk(magSum === 16'(eMag), "R4 magSum", int'(magSum), eMag);
      chk(phsSum === 16'(ePhs), "R5 phsSum", int'(phsSum), ePhs);
      chk(magPass === eMagPass, "R6 magPass", int'(magPass), int'(eMagPass));
      chk(phsPass === ePhsPass, "R7 phsPass", int'(phsPass), int'(ePhsPass));
      chk(qualOk === (eMagPass && ePhsPass), "R8 qualOk", int'(qualOk), int'(eMagPass && ePhsPass));
    end
    if (blockDone === 1'b1) doneCnt++;
  end

  task automatic sendSym(input int m, input int p, input int gap);
    @(negedge clk);
    symValid = 1'b1; magIn = 8'(m); phsErrIn = 8'(p);
    @(negedge clk);
    symValid = 1'b0;
    for (int g = 0; g < gap; g++) begin
      magIn = 8'($urandom_range(255)); phsErrIn = 8'($urandom_range(255)); // R10 ignored samples
      @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int base, wsum;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(blockDone === 1'b0 && magSum === '0 && phsSum === '0, "R1 reset outputs", int'(magSum), 0);
    chk(magPass === 1'b0 && phsPass === 1'b0 && qualOk === 1'b0, "R1 reset flags", int'(qualOk), 0);
    rstN = 1'b1;

    // R2, R6, R7: acquisition window, totals exactly at the limits
    trackMode = 1'b0; magThresh = 16'd160; phsThresh = 16'd80;
    for (int i = 0; i < 15; i++) sendSym(10, 5, i % 3);
    settle();
    chk(doneCnt == 0, "R2 no close before 16", doneCnt, 0);
    sendSym(10, 5, 0);
    settle();
    chk(doneCnt == 1, "R2 close on 16th", doneCnt, 1);
    chk(magPass === 1'b1, "R6 equal passes", int'(magPass), 1);
    chk(phsPass === 1'b0, "R7 equal fails", int'(phsPass), 0);

    // R8: opposite verdicts
    magThresh = 16'd161; phsThresh = 16'd81;
    for (int i = 0; i < 16; i++) sendSym(10, 5, 0);
    settle();
    chk(magPass === 1'b0 && phsPass === 1'b1 && qualOk === 1'b0, "R8 mixed verdict", int'(qualOk), 0);

    // R10, R12: random samples with idle gaps
    magThresh = 16'd1500; phsThresh = 16'd1500;
    wsum = 0;
    for (int i = 0; i < 16; i++) begin
      int m = $urandom_range(255);
      wsum += m;
      sendSym(m, $urandom_range(255), $urandom_range(4));
    end
    settle();
    chk(int'(magSum) == wsum, "R12 fresh window sum", int'(magSum), wsum);
    repeat (5) @(negedge clk);
    chk(int'(magSum) == wsum, "R9 results held", int'(magSum), wsum);

    // R3, R11, R4, R5: long window, mode dropped mid-window, full scale
    base = doneCnt;
    magThresh = 16'd0; phsThresh = 16'hFFFF;
    trackMode = 1'b1;
    for (int i = 0; i < 127; i++) begin
      sendSym(255, 255, 0);
      if (i == 9) trackMode = 1'b0;
    end
    settle();
    chk(doneCnt == base, "R11 window not cut short", doneCnt, base);
    sendSym(255, 255, 0);
    settle();
    chk(doneCnt == base + 1, "R3 close on 128th", doneCnt, base + 1);
    chk(magSum === 16'd32640, "R4 full scale", int'(magSum), 32640);
    chk(phsSum === 16'd32640, "R5 full scale", int'(phsSum), 32640);

    // R11: new mode takes hold on the next window
    for (int i = 0; i < 16; i++) sendSym($urandom_range(255), $urandom_range(255), i % 2);
    settle();
    chk(doneCnt == base + 2, "R11 next window short", doneCnt, base + 2);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule